// File: doc/BRIEF.md
# Dual-Law SPI Bit-Rate Divider

This block derives the serial clock timing of an SPI controller from its module clock. It counts module-clock cycles and emits a single-cycle pulse each time a serial-clock half-period ends. Alongside the pulse it drives a level that toggles on every pulse, which gives a 50% duty square wave at the serial bit rate. The shift engine uses the pulse as its enable for launching and capturing bits.

Software writes one packed settings word holding two divisor fields and a law-select bit. With the select bit set, the half-period lasts N+1 module cycles, so the serial clock runs at the module clock divided by 2(N+1). With the select bit clear, the half-period lasts 2^M module cycles, so the serial clock runs at the module clock divided by 2^(M+1). The field of the law that is not selected is ignored.

New settings never cut a half-period short. While the shift engine reports that a transfer is running, a changed word is copied into the working register only when a half-period ends. While no transfer runs, or while the controller is disabled, the word is copied on every cycle. Dropping the controller enable clears the counter and the output level. The next pulse after the enable returns comes one full half-period later.

Top module: `sclk_rate_gen`

## Requirements
- R1: After reset, `half_tick` and `sclk_phase` are both 0.
- R2: While `enable` is low, `half_tick` stays 0 and `sclk_phase` stays 0. When `enable` is raised, the first `half_tick` arrives H module cycles later, where H is the half-period of the current setting.
- R3: When `cfg_word[12]` is 1 (linear law), H = N+1. Here N is `cfg_word[7:0]`, and pulses repeat every N+1 cycles.
- R4: With the linear law and N = 0, `half_tick` is high on every cycle and `sclk_phase` alternates on every cycle, which is half the module clock rate.
- R5: When `cfg_word[12]` is 0 (power-of-two law), H = 2^M. Here M is `cfg_word[11:8]`.
- R6: `half_tick` lasts one cycle whenever H > 1. `sclk_phase` changes exactly on the cycles where `half_tick` is high, so over one full serial period it is high for H cycles and low for H cycles.
- R7: While `run` and `enable` are high, a change to `cfg_word` does not alter the half-period in progress. It applies from the half-period that follows the next pulse.
- R8: While `run` is low, a change to `cfg_word` is taken up within one cycle. The half-period in progress then ends at the new length, counted from its start.
- R9: The divisor field of the law that is not selected has no effect on the pulse spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low holds the counter and the output level at 0 |
| run | input | 1 | High while the shift engine is in a transfer; restricts setting updates to half-period ends |
| cfg_word | input | 13 | Packed settings: [7:0] linear divisor N, [11:8] exponent M, [12] law select (1 = linear) |
| half_tick | output | 1 | One-cycle pulse at each serial-clock half-period end |
| sclk_phase | output | 1 | Serial-clock level, toggles with each pulse |

## Verification
Every result is counted in module-clock cycles from a known stimulus. When `enable` is raised, the first pulse is due H cycles later, and each later pulse follows H cycles after the one before. A settings change made just after a pulse shows up in the gap to the next pulse when `run` is low. When `run` is high, it shows up in the gap after that. The bench changes inputs and samples outputs only on falling edges. It counts falling edges from the stimulus until a pulse appears, then compares that count with the H computed from the requirement formulas.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Division law chosen by the select bit of the settings word.
  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } div_law_e;

  // Counter width large enough for the longest half-period of either law.
  function automatic int cnt_width(input int lin_w, input int exp_w);
    int pow_w;
    pow_w = 1 << exp_w;
    return (pow_w > lin_w + 1) ? pow_w : lin_w + 1;
  endfunction

endpackage

// File: rtl/sclk_law_decode.sv
module sclk_law_decode
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4,
  parameter int CNT_W = 16
) (
  input  logic [LIN_W+EXP_W:0] cfg_i,
  output logic [CNT_W-1:0]     limit_o
);

  localparam int SEL_BIT = LIN_W + EXP_W;

  logic [LIN_W-1:0] lin_f;
  logic [EXP_W-1:0] exp_f;
  div_law_e         law;
  logic [CNT_W-1:0] pow_lim;

  assign lin_f = cfg_i[LIN_W-1:0];
  assign exp_f = cfg_i[SEL_BIT-1:LIN_W];
  assign law   = div_law_e'(cfg_i[SEL_BIT]);

  // Power-of-two limit 2^M - 1: a run of M ones from bit 0 upward.
  for (genvar i = 0; i < CNT_W; i++) begin : g_pow_mask
    assign pow_lim[i] = (32'(exp_f) > i);
  end

  // Limit is the terminal count, one less than the half-period length.
  always_comb begin
    if (law == LAW_LINEAR) limit_o = CNT_W'(lin_f);
    else                   limit_o = pow_lim;
  end

endmodule

// File: rtl/sclk_cfg_shadow.sv
module sclk_cfg_shadow #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] limit_o
);

  logic load;

  // Copy freely when idle or disabled; otherwise only at a half-period end.
  assign load = !enable || !run || wrap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    limit_o <= '0;
    else if (load) limit_o <= limit_i;
  end

  // R7: during a transfer the working limit changes only at a boundary.
  p_hold_in_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && $past(run) && !$past(wrap_i)) |-> $stable(limit_o))
    else $error("working limit changed mid half-period during a transfer");

endmodule

// File: rtl/sclk_half_counter.sv
module sclk_half_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wrap_o,
  output logic             tick_o,
  output logic             phase_o
);

  logic [CNT_W-1:0] cnt_q;

  // ">=" so that a smaller limit loaded while idle ends the period at once.
  assign wrap_o = enable && (cnt_q >= limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tick_o  <= 1'b0;
      phase_o <= 1'b0;
    end else if (!enable) begin
      cnt_q   <= '0;
      tick_o  <= 1'b0;
      phase_o <= 1'b0;
    end else if (wrap_o) begin
      cnt_q   <= '0;
      tick_o  <= 1'b1;
      phase_o <= ~phase_o;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
      tick_o  <= 1'b0;
    end
  end

  // R2: a disabled cycle leaves both outputs at 0.
  p_idle_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!tick_o && !phase_o))
    else $error("output active after a disabled cycle");

  // R6: pulse is one cycle wide unless the half-period is a single cycle.
  p_tick_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && limit_i != '0) |=> !tick_o)
    else $error("half-period pulse wider than one cycle");

  // R6: level flips on every pulse.
  p_phase_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (phase_o != $past(phase_o)))
    else $error("level did not toggle with pulse");

  // R6: level holds between pulses while enabled.
  p_phase_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !tick_o) |-> $stable(phase_o))
    else $error("level moved without a pulse");

endmodule

// File: rtl/sclk_rate_gen.sv
module sclk_rate_gen
  import sclk_div_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 run,
  input  logic [LIN_W+EXP_W:0] cfg_word,
  output logic                 half_tick,
  output logic                 sclk_phase
);

  localparam int CNT_W = cnt_width(LIN_W, EXP_W);

  logic [CNT_W-1:0] next_limit;
  logic [CNT_W-1:0] work_limit;
  logic             wrap;

  sclk_law_decode #(
    .LIN_W (LIN_W),
    .EXP_W (EXP_W),
    .CNT_W (CNT_W)
  ) u_decode (
    .cfg_i   (cfg_word),
    .limit_o (next_limit)
  );

  sclk_cfg_shadow #(
    .CNT_W (CNT_W)
  ) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .run     (run),
    .wrap_i  (wrap),
    .limit_i (next_limit),
    .limit_o (work_limit)
  );

  sclk_half_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .limit_i (work_limit),
    .wrap_o  (wrap),
    .tick_o  (half_tick),
    .phase_o (sclk_phase)
  );

  // R2: no pulse can follow a disabled cycle.
  p_tick_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |-> $past(enable))
    else $error("pulse after disabled cycle");

endmodule

// File: tb/sclk_rate_gen_bench.sv
module sclk_rate_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_WAIT   = 1000;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        run = 1'b0;
  logic [12:0] cfg_word = '0;
  logic        half_tick;
  logic        sclk_phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  sclk_rate_gen u_sclk_rate_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .run        (run),
    .cfg_word   (cfg_word),
    .half_tick  (half_tick),
    .sclk_phase (sclk_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run exceeded %0d cycles (actual %0d, expected <= %0d)",
               WATCHDOG, cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] mk_cfg(input bit sel, input int m, input int n);
    return {sel, 4'(m), 8'(n)};
  endfunction

  // Count falling edges until a pulse is seen.
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!half_tick && n < MAX_WAIT);
  endtask

  // Disable, load settings, re-enable at a falling edge.
  task automatic restart(input bit sel, input int m, input int n, input bit r);
    @(negedge clk);
    enable   = 1'b0;
    run      = r;
    cfg_word = mk_cfg(sel, m, n);
    @(negedge clk);
    enable   = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(half_tick == 1'b0, "R1 tick", int'(half_tick), 0);
    check(sclk_phase == 1'b0, "R1 phase", int'(sclk_phase), 0);
  endtask

  task automatic t_idle;
    int g;
    int bad;
    bad = 0;
    enable   = 1'b0;
    cfg_word = mk_cfg(1'b1, 0, 0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (half_tick || sclk_phase) bad++;
    end
    check(bad == 0, "R2 quiet while disabled", bad, 0);
    restart(1'b1, 0, 2, 1'b0);
    wait_tick(g);
    check(g == 3, "R2 first pulse after enable", g, 3);
  endtask

  task automatic t_linear;
    int g;
    restart(1'b1, 0, 4, 1'b0);
    wait_tick(g);
    check(g == 5, "R3 N=4 first", g, 5);
    for (int k = 0; k < 2; k++) begin
      wait_tick(g);
      check(g == 5, "R3 N=4 repeat", g, 5);
    end
    restart(1'b1, 0, 9, 1'b0);
    wait_tick(g);
    check(g == 10, "R3 N=9", g, 10);
    wait_tick(g);
    check(g == 10, "R3 N=9 repeat", g, 10);
  endtask

  task automatic t_fastest;
    int bad;
    logic prev;
    restart(1'b1, 0, 0, 1'b0);
    @(negedge clk);
    prev = sclk_phase;
    check(half_tick == 1'b1, "R4 first pulse", int'(half_tick), 1);
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!half_tick || sclk_phase == prev) bad++;
      prev = sclk_phase;
    end
    check(bad == 0, "R4 pulse and toggle every cycle", bad, 0);
  endtask

  task automatic t_pow;
    int g;
    int ms[4] = '{2, 3, 5, 0};
    foreach (ms[j]) begin
      restart(1'b0, ms[j], 0, 1'b0);
      wait_tick(g);
      check(g == (1 << ms[j]), "R5 first", g, 1 << ms[j]);
      wait_tick(g);
      check(g == (1 << ms[j]), "R5 repeat", g, 1 << ms[j]);
    end
  endtask

  task automatic t_duty;
    int g;
    int hi;
    int tk;
    restart(1'b1, 0, 3, 1'b0);
    wait_tick(g);
    hi = 0;
    tk = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sclk_phase) hi++;
      if (half_tick) tk++;
    end
    check(hi == 4, "R6 high cycles per period", hi, 4);
    check(tk == 2, "R6 pulses per period", tk, 2);
  endtask

  task automatic t_run_hold;
    int g;
    restart(1'b1, 0, 3, 1'b1);
    wait_tick(g);
    check(g == 4, "R7 start", g, 4);
    cfg_word = mk_cfg(1'b1, 0, 1);
    wait_tick(g);
    check(g == 4, "R7 current half-period kept", g, 4);
    wait_tick(g);
    check(g == 2, "R7 new setting after boundary", g, 2);
    run = 1'b0;
  endtask

  task automatic t_idle_update;
    int g;
    restart(1'b1, 0, 3, 1'b0);
    wait_tick(g);
    cfg_word = mk_cfg(1'b1, 0, 1);
    wait_tick(g);
    check(g == 2, "R8 shorter taken at once", g, 2);
    cfg_word = mk_cfg(1'b1, 0, 6);
    wait_tick(g);
    check(g == 7, "R8 longer taken at once", g, 7);
  endtask

  task automatic t_unused;
    int g;
    restart(1'b1, 0, 2, 1'b0);
    wait_tick(g);
    cfg_word = mk_cfg(1'b1, 7, 2);
    wait_tick(g);
    check(g == 3, "R9 exponent ignored in linear law", g, 3);
    restart(1'b0, 1, 0, 1'b0);
    wait_tick(g);
    cfg_word = mk_cfg(1'b0, 1, 200);
    wait_tick(g);
    check(g == 2, "R9 linear field ignored in power law", g, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_idle();
    t_linear();
    t_fastest();
    t_pow();
    t_duty();
    t_run_hold();
    t_idle_update();
    t_unused();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule